// File: doc/BRIEF.md
# Packet FIFO Bridge Interrupt and Reset Register Unit

This unit is the register and interrupt block of a bridge that moves packets between a processor-visible register window and a pair of stream FIFOs. It keeps a 32-bit latched status word with thirteen event bits, a matching enable mask, and one active-high interrupt line. The transmit and receive controllers report their events on single-cycle pulse inputs. The unit also compares the two FIFO fill levels against parameterised full and empty thresholds, and latches an event when a level first reaches one of them.

Three write-only key locations ask for a reset of the transmit path, the receive path, or the whole core. A request is accepted only when the written word is exactly 0x000000A5. A whole-core request also drives three active-low reset lines toward the stream partners for one cycle and returns this unit's own registers to their power-up values.

Register reads are combinational from the offset. Writes take effect on the clock edge where the write strobe is high.

Top module: `fifo_irq_hub`

## Requirements
- R1: After reset the status word at offset 0x00 reads 0x01800000 and the enable word at offset 0x04 reads 0. irq_o, tx_rst_req_o, rx_rst_req_o and core_rst_o are low, and txd_rst_n_o, txc_rst_n_o and rxd_rst_n_o are high.
- R2: Status bits 18 down to 0 always read 0. The enable word stores only bits 31 down to 19, so writing 0xFFFFFFFF to offset 0x04 reads back 0xFFF80000.
- R3: A write to offset 0x00 clears each status bit where the written data has a 1. Status bits where the data has a 0 are unchanged, and several bits can be cleared in one write.
- R4: A one-cycle pulse on an event input sets its status bit, and the bit stays set after the pulse ends. The bit assignments are: tx_size_err_i to bit 25, rx_done_i to 26, tx_done_i to 27, tx_overrun_i to 28, rx_underrun_i to 29, rx_overread_i to 30, and rx_len_underrun_i to 31.
- R5: irq_o is high exactly when some status bit is 1 and the enable bit at the same position is also 1.
- R6: If an event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R7: Writing exactly 0x000000A5 to offset 0x08 raises tx_rst_req_o for one cycle, starting in the cycle after the write. The same write to offset 0x18 does this for rx_rst_req_o. Any other data written to these offsets raises nothing.
- R8: Writing exactly 0x000000A5 to offset 0x28 raises core_rst_o for one cycle, starting in the cycle after the write. In that same cycle txd_rst_n_o, txc_rst_n_o and rxd_rst_n_o are low, status reads 0x01800000 and enable reads 0. Any other data written to offset 0x28 has no effect.
- R9: Offsets 0x34, 0x38 and 0x3C, and also the key offsets, read 0. Writes to 0x34 through 0x3C change neither status nor enable.
- R10: When tx_level_i rises to TX_FULL_TH or above, status bit 22 is set. When rx_level_i rises to RX_FULL_TH or above, bit 20 is set. If the bit is cleared while the level stays at or above the threshold, the bit is not set again.
- R11: When tx_level_i falls from above TX_EMPTY_TH to TX_EMPTY_TH or below, status bit 21 is set. The receive side does the same on bit 19 with RX_EMPTY_TH. The levels count as empty at reset, so a level that stays low after reset sets nothing.
- R12: A pulse on rx_rst_done_i sets status bit 23, and a pulse on tx_rst_done_i sets bit 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| tx_size_err_i | input | 1 | Transmit word count mismatch pulse |
| tx_done_i | input | 1 | Transmit packet finished pulse |
| tx_overrun_i | input | 1 | Write into a full transmit FIFO pulse |
| tx_rst_done_i | input | 1 | Transmit reset finished pulse |
| rx_done_i | input | 1 | Receive packet stored pulse |
| rx_underrun_i | input | 1 | Read from an empty receive FIFO pulse |
| rx_overread_i | input | 1 | Read past the end of the packet pulse |
| rx_len_underrun_i | input | 1 | Read of an empty length queue pulse |
| rx_rst_done_i | input | 1 | Receive reset finished pulse |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| irq_o | output | 1 | Interrupt, active high |
| tx_rst_req_o | output | 1 | Transmit path reset request pulse |
| rx_rst_req_o | output | 1 | Receive path reset request pulse |
| core_rst_o | output | 1 | Whole-core reset pulse |
| txd_rst_n_o | output | 1 | Transmit data stream partner reset, active low |
| txc_rst_n_o | output | 1 | Transmit control stream partner reset, active low |
| rxd_rst_n_o | output | 1 | Receive data stream partner reset, active low |

## Verification
The bench builds the unit with a FIFO depth of 32. The transmit thresholds are 30 for full and 3 for empty, and the receive thresholds are 28 and 4. Because the two sides use different thresholds, a mix-up between the transmit and receive comparisons shows up. The levels just below, at, and back away from each threshold are driven directly, so both edge-only threshold events and their sticky bits are reached in a few cycles. The default depth of 512 changes only the comparison width.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;

    // status bit positions (software decodes these)
    localparam int B_RX_PE     = 19;
    localparam int B_RX_PF     = 20;
    localparam int B_TX_PE     = 21;
    localparam int B_TX_PF     = 22;
    localparam int B_RX_RDONE  = 23;
    localparam int B_TX_RDONE  = 24;
    localparam int B_TX_SIZE   = 25;
    localparam int B_RX_DONE   = 26;
    localparam int B_TX_DONE   = 27;
    localparam int B_TX_OVR    = 28;
    localparam int B_RX_UNDR   = 29;
    localparam int B_RX_OVRD   = 30;
    localparam int B_RX_LUNDR  = 31;

    localparam int EV_LO       = 19;
    localparam int EV_N        = 32 - EV_LO;

    localparam logic [31:0] RST_KEY   = 32'h0000_00A5;
    localparam logic [31:0] STAT_INIT = 32'h0180_0000;

    localparam int OFS_STAT = 'h00;
    localparam int OFS_EN   = 'h04;
    localparam int OFS_TXK  = 'h08;
    localparam int OFS_RXK  = 'h18;
    localparam int OFS_COREK = 'h28;

    typedef struct packed {
        logic tx;
        logic rx;
        logic core;
    } key_hits_t;

endpackage

// File: rtl/irqhub_key_decode.sv
module irqhub_key_decode
    import irqhub_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output key_hits_t         hits_o,
    output logic [31:0]       clr_mask_o,
    output logic              en_we_o
);

    logic key_ok;

    always_comb begin
        key_ok      = (wdata_i == RST_KEY);
        hits_o.tx   = we_i && key_ok && (addr_i == ADDR_W'(OFS_TXK));
        hits_o.rx   = we_i && key_ok && (addr_i == ADDR_W'(OFS_RXK));
        hits_o.core = we_i && key_ok && (addr_i == ADDR_W'(OFS_COREK));
        clr_mask_o  = (we_i && addr_i == ADDR_W'(OFS_STAT)) ? wdata_i : 32'h0;
        en_we_o     = we_i && (addr_i == ADDR_W'(OFS_EN));
    end

endmodule

// File: rtl/irqhub_level_watch.sv
module irqhub_level_watch #(
    parameter int LVL_W    = 10,
    parameter int FULL_TH  = 510,
    parameter int EMPTY_TH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             ev_full_o,
    output logic             ev_empty_o
);

    localparam logic [LVL_W-1:0] FULL_L  = LVL_W'(FULL_TH);
    localparam logic [LVL_W-1:0] EMPTY_L = LVL_W'(EMPTY_TH);

    typedef struct packed {
        logic full;
        logic empty;
    } watch_t;

    watch_t w_d, w_q;

    always_comb begin
        w_d.full   = (lvl_i >= FULL_L);
        w_d.empty  = (lvl_i <= EMPTY_L);
        ev_full_o  = w_d.full  && !w_q.full;
        ev_empty_o = w_d.empty && !w_q.empty;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q.full  <= 1'b0;
            w_q.empty <= 1'b1;
        end else begin
            w_q <= w_d;
        end
    end

    // R10: a full event only with the level at or above the threshold, never two in a row
    a_r10_full_at_level: assert property (@(posedge clk) disable iff (!rst_n)
        ev_full_o |-> (lvl_i >= FULL_L));
    a_r10_full_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        ev_full_o |=> !ev_full_o);
    // R11: an empty event only with the level at or below the threshold
    a_r11_empty_at_level: assert property (@(posedge clk) disable iff (!rst_n)
        ev_empty_o |-> (lvl_i <= EMPTY_L));

endmodule

// File: rtl/fifo_irq_hub.sv
module fifo_irq_hub
    import irqhub_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DEPTH       = 512,
    parameter int TX_FULL_TH  = 510,
    parameter int TX_EMPTY_TH = 2,
    parameter int RX_FULL_TH  = 510,
    parameter int RX_EMPTY_TH = 2,
    parameter int LVL_W       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tx_size_err_i,
    input  logic              tx_done_i,
    input  logic              tx_overrun_i,
    input  logic              tx_rst_done_i,
    input  logic              rx_done_i,
    input  logic              rx_underrun_i,
    input  logic              rx_overread_i,
    input  logic              rx_len_underrun_i,
    input  logic              rx_rst_done_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    input  logic [LVL_W-1:0]  rx_level_i,
    output logic              irq_o,
    output logic              tx_rst_req_o,
    output logic              rx_rst_req_o,
    output logic              core_rst_o,
    output logic              txd_rst_n_o,
    output logic              txc_rst_n_o,
    output logic              rxd_rst_n_o
);

    typedef struct packed {
        logic [31:0]     st;
        logic [EV_N-1:0] en;
        logic            tx_req;
        logic            rx_req;
        logic            core;
    } hub_t;

    hub_t        h_d, h_q;
    key_hits_t   hits;
    logic [31:0] clr_mask;
    logic        en_we;
    logic [31:0] set_v;
    logic [1:0]  ev_full, ev_empty;
    logic [LVL_W-1:0] lvls [2];

    assign lvls[0] = tx_level_i;
    assign lvls[1] = rx_level_i;

    irqhub_key_decode #(.ADDR_W(ADDR_W)) i_dec (
        .we_i      (reg_we),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .hits_o    (hits),
        .clr_mask_o(clr_mask),
        .en_we_o   (en_we)
    );

    // index 0 watches transmit, index 1 watches receive
    for (genvar g = 0; g < 2; g++) begin : g_watch
        localparam int FTH = (g == 0) ? TX_FULL_TH  : RX_FULL_TH;
        localparam int ETH = (g == 0) ? TX_EMPTY_TH : RX_EMPTY_TH;
        irqhub_level_watch #(
            .LVL_W(LVL_W), .FULL_TH(FTH), .EMPTY_TH(ETH)
        ) i_watch (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_i     (lvls[g]),
            .ev_full_o (ev_full[g]),
            .ev_empty_o(ev_empty[g])
        );
    end

    always_comb begin
        set_v             = 32'h0;
        set_v[B_RX_PE]    = ev_empty[1];
        set_v[B_RX_PF]    = ev_full[1];
        set_v[B_TX_PE]    = ev_empty[0];
        set_v[B_TX_PF]    = ev_full[0];
        set_v[B_RX_RDONE] = rx_rst_done_i;
        set_v[B_TX_RDONE] = tx_rst_done_i;
        set_v[B_TX_SIZE]  = tx_size_err_i;
        set_v[B_RX_DONE]  = rx_done_i;
        set_v[B_TX_DONE]  = tx_done_i;
        set_v[B_TX_OVR]   = tx_overrun_i;
        set_v[B_RX_UNDR]  = rx_underrun_i;
        set_v[B_RX_OVRD]  = rx_overread_i;
        set_v[B_RX_LUNDR] = rx_len_underrun_i;

        h_d           = h_q;
        h_d.st        = (h_q.st & ~clr_mask) | set_v;
        h_d.st[EV_LO-1:0] = '0;
        if (en_we) h_d.en = reg_wdata[31:EV_LO];
        h_d.tx_req    = hits.tx;
        h_d.rx_req    = hits.rx;
        h_d.core      = hits.core;
        if (hits.core) begin
            h_d.st = STAT_INIT;
            h_d.en = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q.st     <= STAT_INIT;
            h_q.en     <= '0;
            h_q.tx_req <= 1'b0;
            h_q.rx_req <= 1'b0;
            h_q.core   <= 1'b0;
        end else begin
            h_q <= h_d;
        end
    end

    always_comb begin
        irq_o        = |(h_q.st[31:EV_LO] & h_q.en);
        tx_rst_req_o = h_q.tx_req;
        rx_rst_req_o = h_q.rx_req;
        core_rst_o   = h_q.core;
        txd_rst_n_o  = !h_q.core;
        txc_rst_n_o  = !h_q.core;
        rxd_rst_n_o  = !h_q.core;
        case (reg_addr)
            ADDR_W'(OFS_STAT): reg_rdata = h_q.st;
            ADDR_W'(OFS_EN):   reg_rdata = {h_q.en, {EV_LO{1'b0}}};
            default:           reg_rdata = 32'h0;
        endcase
    end

    // R2: low status bits never hold a 1
    a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        h_q.st[EV_LO-1:0] == '0);
    // R3: no set bit drops unless a clear or core reset asked for it
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !hits.core |=> (($past(h_q.st) & ~$past(clr_mask) & ~h_q.st) == 32'h0));
    // R6: an event always lands, even against a same-cycle clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v && !hits.core) |=> ((h_q.st & $past(set_v)) == $past(set_v)));
    // R7: port-level key write produces the request pulse
    a_r7_tx_key: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(OFS_TXK) && reg_wdata == RST_KEY) |=> tx_rst_req_o);
    a_r7_rx_no_key: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == ADDR_W'(OFS_RXK) && reg_wdata == RST_KEY) |=> !rx_rst_req_o);
    // R8: core reset pulse comes with power-up register values and partner resets low
    a_r8_core_state: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |-> (reg_we || 1'b1) && h_q.st == STAT_INIT && h_q.en == '0
                       && !txd_rst_n_o && !rxd_rst_n_o);

endmodule

// File: tb/test_fifo_irq_hub.sv
module test_fifo_irq_hub;

    localparam int ADDR_W = 8;
    localparam int DEPTH  = 32;
    localparam int LVL_W  = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [8:0]  ev = '0;
    logic [LVL_W-1:0] tx_lvl = '0, rx_lvl = '0;
    logic irq, txr, rxr, corer, txd_n, txc_n, rxd_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fifo_irq_hub #(
        .ADDR_W(ADDR_W), .DEPTH(DEPTH),
        .TX_FULL_TH(30), .TX_EMPTY_TH(3),
        .RX_FULL_TH(28), .RX_EMPTY_TH(4)
    ) i_fifo_irq_hub (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_size_err_i(ev[0]), .rx_done_i(ev[1]), .tx_done_i(ev[2]),
        .tx_overrun_i(ev[3]), .rx_underrun_i(ev[4]), .rx_overread_i(ev[5]),
        .rx_len_underrun_i(ev[6]), .rx_rst_done_i(ev[7]), .tx_rst_done_i(ev[8]),
        .tx_level_i(tx_lvl), .rx_level_i(rx_lvl),
        .irq_o(irq), .tx_rst_req_o(txr), .rx_rst_req_o(rxr), .core_rst_o(corer),
        .txd_rst_n_o(txd_n), .txc_rst_n_o(txc_n), .rxd_rst_n_o(rxd_n)
    );

    // status bit expected for each event input index
    function automatic int ev_bit(int i);
        case (i)
            0: return 25; 1: return 26; 2: return 27; 3: return 28;
            4: return 29; 5: return 30; 6: return 31; 7: return 23;
            default: return 24;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(int i);
        @(negedge clk);
        ev[i] = 1'b1;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); check("R1 status", d, 32'h0180_0000);
        rd(8'h04, d); check("R1 enable", d, 32'h0);
        check("R1 outs", {irq, txr, rxr, corer, txd_n, txc_n, rxd_n}, 32'b0000111);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(8'h00, 32'h0080_0000);
        rd(8'h00, d); check("R3 clear one", d, 32'h0100_0000);
        wr(8'h00, 32'h0000_0000);
        rd(8'h00, d); check("R3 write zero", d, 32'h0100_0000);
        wr(8'h00, 32'hFEFF_FFFF);
        rd(8'h00, d); check("R3 ones on zero bits", d, 32'h0100_0000);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); check("R3 all clear", d, 32'h0);
    endtask

    task automatic t_events();
        logic [31:0] d;
        for (int i = 0; i < 9; i++) begin
            pulse(i);
            @(negedge clk);
            rd(8'h00, d);
            check((i >= 7) ? "R12 reset done bit" : "R4 event bit", d, 32'h1 << ev_bit(i));
            wr(8'h00, 32'h1 << ev_bit(i));
        end
        pulse(0); pulse(6);
        rd(8'h00, d); check("R3 multi clear setup", d, 32'h8200_0000);
        wr(8'h00, 32'h8200_0000);
        rd(8'h00, d); check("R3 multi clear", d, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d); check("R2 enable readback", d, 32'hFFF8_0000);
        check("R5 no status no irq", {31'b0, irq}, 32'h0);
        wr(8'h04, 32'h0400_0000);
        pulse(2);
        check("R5 disabled bit no irq", {31'b0, irq}, 32'h0);
        pulse(1);
        check("R5 enabled bit irq", {31'b0, irq}, 32'h1);
        wr(8'h00, 32'h0400_0000);
        check("R5 cleared irq", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        pulse(3);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h1000_0000; ev[3] = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; ev = '0;
        rd(8'h00, d); check("R6 set beats clear", d, 32'h1000_0000);
        wr(8'h00, 32'hFFFF_FFFF);
    endtask

    task automatic t_keys();
        logic [31:0] d;
        wr(8'h08, 32'hA5);
        check("R7 tx pulse", {30'b0, txr, rxr}, 32'h2);
        @(negedge clk);
        check("R7 tx pulse one cycle", {31'b0, txr}, 32'h0);
        wr(8'h18, 32'hA5);
        check("R7 rx pulse", {30'b0, txr, rxr}, 32'h1);
        wr(8'h08, 32'hA4);
        check("R7 wrong tx key", {30'b0, txr, rxr}, 32'h0);
        wr(8'h18, 32'h1A5);
        check("R7 wrong rx key", {30'b0, txr, rxr}, 32'h0);
        rd(8'h08, d); check("R9 key offset reads zero", d, 32'h0);
    endtask

    task automatic t_core();
        logic [31:0] d;
        wr(8'h04, 32'h8000_0000);
        pulse(4);
        wr(8'h28, 32'hA4);
        check("R8 wrong key no pulse", {28'b0, corer, txd_n, txc_n, rxd_n}, 32'h7);
        rd(8'h00, d); check("R8 wrong key keeps status", d, 32'h2000_0000);
        wr(8'h28, 32'hA5);
        check("R8 core pulse", {28'b0, corer, txd_n, txc_n, rxd_n}, 32'h8);
        #1 reg_addr = 8'h00;
        #1 check("R8 status restored", reg_rdata, 32'h0180_0000);
        reg_addr = 8'h04;
        #1 check("R8 enable cleared", reg_rdata, 32'h0);
        @(negedge clk);
        check("R8 pulse ends", {28'b0, corer, txd_n, txc_n, rxd_n}, 32'h7);
        wr(8'h00, 32'hFFFF_FFFF);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(8'h04, 32'h0200_0000);
        for (int a = 'h34; a <= 'h3C; a += 4) begin
            wr(a[7:0], 32'hFFFF_FFFF);
            rd(a[7:0], d); check("R9 reserved reads zero", d, 32'h0);
        end
        rd(8'h04, d); check("R9 enable untouched", d, 32'h0200_0000);
        rd(8'h00, d); check("R9 status untouched", d, 32'h0);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_levels();
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rd(8'h00, d); check("R11 low after reset no event", d, 32'h0);
        tx_lvl = 29; rx_lvl = 27;
        repeat (2) @(negedge clk);
        rd(8'h00, d); check("R10 below full", d, 32'h0);
        tx_lvl = 30;
        repeat (2) @(negedge clk);
        rd(8'h00, d); check("R10 tx full", d, 32'h0040_0000);
        rx_lvl = 28;
        repeat (2) @(negedge clk);
        rd(8'h00, d); check("R10 rx full", d, 32'h0050_0000);
        wr(8'h00, 32'h0050_0000);
        repeat (3) @(negedge clk);
        rd(8'h00, d); check("R10 no refire while full", d, 32'h0);
        tx_lvl = 4; rx_lvl = 5;
        repeat (2) @(negedge clk);
        rd(8'h00, d); check("R11 above empty", d, 32'h0);
        tx_lvl = 3;
        repeat (2) @(negedge clk);
        rd(8'h00, d); check("R11 tx empty", d, 32'h0020_0000);
        rx_lvl = 4;
        repeat (2) @(negedge clk);
        rd(8'h00, d); check("R11 rx empty", d, 32'h0028_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clear();
        t_events();
        t_irq();
        t_race();
        t_keys();
        t_core();
        t_reserved();
        t_levels();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule